// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block steers eight shared, level-sensitive PCI interrupt lines (PIRQ0 through PIRQ7) and one power-management SCI line onto the inputs of a 16-input legacy PIC and a 24-input I/O APIC. Every output is a level. The level of a PIC input is the OR of every PIRQ line that is routed to it and enabled, plus the SCI when the SCI is steered there. The APIC side has a fixed path: PIRQn drives APIC input 16+n, and no two lines share an APIC input.

Software programs the block through a byte-wide register-write port. The port holds eight route bytes, split into two groups of four, and a 3-bit SCI destination select. A second write port loads a per-slot swizzle table. That table tells the bus fabric which PIRQ line a device's pin INTA..INTD lands on. The fabric asks the table through a slot/pin lookup port. A readback port returns a slot's table word.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte holds 0x80, which has the disable bit set, so no PIC input is driven by any PIRQ line. The SCI select resets to 0 and the stored SCI level resets low.
- R2: Route bytes are written at cfg_addr 0x0..0x3 for PIRQ0..PIRQ3 and at 0x8..0xB for PIRQ4..PIRQ7. The SCI select is written at 0xC from cfg_wdata[2:0]. A write to any other address changes nothing.
- R3: A route byte is decoded as follows. Bits [4:0] give the PIC target and bit 7 set disables the route. Each PIC input is the OR of all PIRQ lines that are high, enabled, and aimed at that input.
- R4: A PIRQ line whose route byte has bit 7 set never drives a PIC input.
- R5: An enabled route whose PIC target is 16 or more drives no PIC input.
- R6: APIC input 16+n follows PIRQn whatever its route byte holds. APIC inputs 0..15 carry only the SCI.
- R7: SCI select codes map as 0→9, 1→10, 2→11, 4→20 and 5→21. Codes 3, 6 and 7 send the SCI nowhere. The SCI is ORed into the APIC input of that number, and also into the PIC input when the number is below 16.
- R8: The SCI level is stored in a register, so a change on sci_lvl appears at the outputs one clock later. When the input equals the stored level, the stored level is held.
- R9: After reset the swizzle table maps pin p of slot s to PIRQ ((s+p) mod 4)+4. Pin codes are 0=INTA .. 3=INTD.
- R10: A table write takes a 16-bit word. Bits [4p+2:4p] give the PIRQ for pin p. Readback returns the same layout, with bit 4p+3 reading zero.
- R11: Slot 30 is fixed: pin p looks up PIRQ p+4. Writes to slot 30 are ignored and its readback word is zero.
- R12: Route and select writes affect the outputs from the clock edge that stores them. PIRQ input levels reach the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Route/SCI register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pirq_lvl | input | 8 | Levels of PIRQ0..PIRQ7 |
| sci_lvl | input | 1 | SCI request level |
| tbl_we | input | 1 | Swizzle table write strobe |
| tbl_slot | input | 5 | Slot written |
| tbl_wdata | input | 16 | Table word, 4 bits per pin |
| tbl_rd_slot | input | 5 | Slot read back |
| tbl_rd_data | output | 16 | Table word read back |
| lk_slot | input | 5 | Lookup slot |
| lk_pin | input | 2 | Lookup pin, 0=INTA |
| lk_pirq | output | 3 | PIRQ number for the looked-up pin |
| pic_irq | output | 16 | Level per PIC input |
| apic_irq | output | 24 | Level per APIC input |

## Verification
A fixed route setting is applied, and single-line patterns are walked across all eight PIRQ lines. This shows which lines are enabled, which are disabled and which are out of range. Patterns with two lines on the same PIC input check that they merge by OR rather than override. Full and alternating patterns check that distinct targets stay independent, while the APIC upper byte must always mirror the input. Each SCI select code is tried with all PIRQ lines quiet, which separates PIC-visible codes from APIC-only and reserved codes. The swizzle table is probed through the default formula, through a written slot and through the fixed slot.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int TGT_W     = 5;
  localparam int SCI_SEL_W = 3;
  localparam int GSI_W     = 5;

  // Route byte: bit 7 disables the PIC path, bits 4:0 pick the PIC input.
  typedef struct packed {
    logic             off;
    logic [1:0]       spare;
    logic [TGT_W-1:0] tgt;
  } route_t;

  localparam logic [7:0] ROUTE_RESET = 8'h80;

  typedef struct packed {
    logic             live;
    logic [GSI_W-1:0] gsi;
  } sci_dest_t;

  // SCI destination decode; reserved codes give live = 0.
  function automatic sci_dest_t sci_dest(input logic [SCI_SEL_W-1:0] sel);
    sci_dest_t d;
    d.live = 1'b1;
    case (sel)
      3'd0:    d.gsi = 5'd9;
      3'd1:    d.gsi = 5'd10;
      3'd2:    d.gsi = 5'd11;
      3'd4:    d.gsi = 5'd20;
      3'd5:    d.gsi = 5'd21;
      default: begin d.live = 1'b0; d.gsi = '0; end
    endcase
    return d;
  endfunction

  // True when an enabled route aims at PIC input idx.
  function automatic logic drives_pic(input route_t r, input int unsigned idx);
    return !r.off && ({27'd0, r.tgt} == idx);
  endfunction

  // Register address of the route byte for line n: two groups of four.
  function automatic int unsigned route_addr(input int unsigned n);
    return (n < 4) ? n : 8 + (n - 4);
  endfunction

  // Reset swizzle: only the upper four lines are used.
  function automatic logic [2:0] swizzle_default(input int unsigned slot,
                                                 input int unsigned pin);
    return 3'(((slot + pin) % 4) + 4);
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int ADDR_W   = 4,
  parameter int SCI_ADDR = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [7:0]             cfg_wdata,
  input  logic                   sci_lvl,
  output route_t [NUM_PIRQ-1:0]  routes,
  output logic [SCI_SEL_W-1:0]   sci_sel,
  output logic                   sci_q
);

  logic sci_change;
  assign sci_change = (sci_lvl != sci_q);

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(route_addr(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        routes[n] <= route_t'(ROUTE_RESET);
      else if (cfg_we && cfg_addr == MY_ADDR)
        routes[n] <= route_t'(cfg_wdata);
    end

    // R2: a write to this line's address lands in this line's byte.
    assert_route_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == MY_ADDR) |=> (routes[n] == route_t'($past(cfg_wdata))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sci_sel <= '0;
    else if (cfg_we && cfg_addr == ADDR_W'(SCI_ADDR))
      sci_sel <= cfg_wdata[SCI_SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sci_q <= 1'b0;
    else if (sci_change)
      sci_q <= sci_lvl;
  end

  // R8: a repeated SCI level leaves the stored level untouched.
  assert_sci_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_change |=> $stable(sci_q));

  // R8: a new SCI level is stored one clock later.
  assert_sci_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sci_change |=> (sci_q == $past(sci_lvl)));

endmodule

// File: rtl/pirq_slot_table.sv
module pirq_slot_table
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int FIXED_SLOT = 30,
  parameter int PIN_N      = 4,
  parameter int FIELD_W    = 4,
  parameter int PIRQ_W     = 3,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int PIN_W     = $clog2(PIN_N),
  localparam int WORD_W    = PIN_N * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic [SLOT_W-1:0] tbl_rd_slot,
  output logic [WORD_W-1:0] tbl_rd_data,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [PIN_W-1:0]  lk_pin,
  output logic [PIRQ_W-1:0] lk_pirq
);

  localparam logic [SLOT_W-1:0] FIXED_IDX  = SLOT_W'(FIXED_SLOT);
  localparam logic [PIRQ_W-1:0] FIXED_BASE = PIRQ_W'(PIN_N);

  logic [PIRQ_W-1:0] ent [NUM_SLOTS][PIN_N];
  logic              wr_hit;

  assign wr_hit = tbl_we && (tbl_slot != FIXED_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int p = 0; p < PIN_N; p++)
          ent[s][p] <= swizzle_default(s, p);
    end else if (wr_hit) begin
      for (int p = 0; p < PIN_N; p++)
        ent[tbl_slot][p] <= tbl_wdata[p*FIELD_W +: PIRQ_W];
    end
  end

  always_comb begin
    tbl_rd_data = '0;
    if (tbl_rd_slot != FIXED_IDX)
      for (int p = 0; p < PIN_N; p++)
        tbl_rd_data[p*FIELD_W +: FIELD_W] = FIELD_W'(ent[tbl_rd_slot][p]);
  end

  assign lk_pirq = (lk_slot == FIXED_IDX) ? (FIXED_BASE + PIRQ_W'(lk_pin))
                                          : ent[lk_slot][lk_pin];

  // R10: a table write is returned on lookup of pin 0 one clock later.
  assert_tbl_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lk_slot == tbl_slot && lk_pin == '0 && $stable(lk_slot) && $stable(lk_pin))
      |=> (lk_pirq == $past(tbl_wdata[PIRQ_W-1:0])));

  // R11: the fixed slot only ever names one of the upper lines.
  assert_fixed_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == FIXED_IDX) |-> (lk_pirq >= FIXED_BASE));

endmodule

// File: rtl/pirq_level_merge.sv
module pirq_level_merge
  import pirq_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int PIC_N    = 16,
  parameter int APIC_N   = 24
) (
  input  route_t [NUM_PIRQ-1:0] routes,
  input  logic [NUM_PIRQ-1:0]   pirq_lvl,
  input  logic [SCI_SEL_W-1:0]  sci_sel,
  input  logic                  sci_q,
  output logic [APIC_N-1:0]     sci_hit,
  output logic [PIC_N-1:0]      pic_out,
  output logic [APIC_N-1:0]     apic_out
);

  sci_dest_t dest;
  assign dest = sci_dest(sci_sel);

  for (genvar g = 0; g < APIC_N; g++) begin : g_sci
    assign sci_hit[g] = dest.live && (dest.gsi == GSI_W'(g));
  end

  for (genvar i = 0; i < PIC_N; i++) begin : g_pic
    logic [NUM_PIRQ-1:0] hits;
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_src
      assign hits[n] = pirq_lvl[n] && drives_pic(routes[n], i);
    end
    assign pic_out[i] = (|hits) || (sci_q && sci_hit[i]);
  end

  for (genvar g = 0; g < APIC_N; g++) begin : g_apic
    if (g >= PIC_N && (g - PIC_N) < NUM_PIRQ) begin : g_line
      assign apic_out[g] = pirq_lvl[g-PIC_N] || (sci_q && sci_hit[g]);
    end else begin : g_sci_only
      assign apic_out[g] = sci_q && sci_hit[g];
    end
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int PIC_N      = 16,
  parameter int APIC_N     = 24,
  parameter int NUM_SLOTS  = 32,
  parameter int FIXED_SLOT = 30,
  parameter int PIN_N      = 4,
  parameter int ADDR_W     = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int PIN_W     = $clog2(PIN_N),
  localparam int PIRQ_W    = $clog2(NUM_PIRQ),
  localparam int WORD_W    = PIN_N * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [NUM_PIRQ-1:0] pirq_lvl,
  input  logic              sci_lvl,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic [SLOT_W-1:0] tbl_rd_slot,
  output logic [WORD_W-1:0] tbl_rd_data,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [PIN_W-1:0]  lk_pin,
  output logic [PIRQ_W-1:0] lk_pirq,
  output logic [PIC_N-1:0]  pic_irq,
  output logic [APIC_N-1:0] apic_irq
);

  route_t [NUM_PIRQ-1:0]  routes;
  logic [SCI_SEL_W-1:0]   sci_sel;
  logic                   sci_q;
  logic [APIC_N-1:0]      sci_hit;
  logic                   any_route_on;

  pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sci_lvl(sci_lvl), .routes(routes),
    .sci_sel(sci_sel), .sci_q(sci_q)
  );

  pirq_slot_table #(.NUM_SLOTS(NUM_SLOTS), .FIXED_SLOT(FIXED_SLOT),
                    .PIN_N(PIN_N), .FIELD_W(4), .PIRQ_W(PIRQ_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_slot(tbl_slot),
    .tbl_wdata(tbl_wdata), .tbl_rd_slot(tbl_rd_slot), .tbl_rd_data(tbl_rd_data),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
  );

  pirq_level_merge #(.NUM_PIRQ(NUM_PIRQ), .PIC_N(PIC_N), .APIC_N(APIC_N)) u_merge (
    .routes(routes), .pirq_lvl(pirq_lvl), .sci_sel(sci_sel), .sci_q(sci_q),
    .sci_hit(sci_hit), .pic_out(pic_irq), .apic_out(apic_irq)
  );

  always_comb begin
    any_route_on = 1'b0;
    for (int n = 0; n < NUM_PIRQ; n++)
      if (!routes[n].off) any_route_on = 1'b1;
  end

  // R6: with the SCI quiet the upper APIC inputs mirror the PIRQ lines.
  assert_apic_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_q |-> (apic_irq[PIC_N +: NUM_PIRQ] == pirq_lvl));

  // R6: the lower APIC inputs never carry a PIRQ line.
  assert_apic_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_q |-> (apic_irq[PIC_N-1:0] == '0));

  // R3: no PIC input rises without a high PIRQ line or the SCI.
  assert_pic_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_q && pirq_lvl == '0) |-> (pic_irq == '0));

  // R4: with every route disabled only the SCI can reach the PIC.
  assert_pic_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_route_on && !sci_q) |-> (pic_irq == '0));

  // R7: the SCI has at most one destination.
  assert_sci_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sci_hit));

endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_slot = '0;
  logic [15:0] tbl_wdata = '0;
  logic [4:0]  tbl_rd_slot = '0;
  logic [15:0] tbl_rd_data;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  logic [15:0] pic_irq;
  logic [23:0] apic_irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pirq_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_wdata(tbl_wdata),
    .tbl_rd_slot(tbl_rd_slot), .tbl_rd_data(tbl_rd_data),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq),
    .pic_irq(pic_irq), .apic_irq(apic_irq)
  );

  // {pirq pattern, expected PIC word} under the fixed route setting below.
  localparam logic [23:0] VEC [13] = '{
    {8'h00, 16'h0000}, {8'h01, 16'h0020}, {8'h02, 16'h0020},
    {8'h03, 16'h0020}, {8'h04, 16'h0000}, {8'h08, 16'h0000},
    {8'h10, 16'h0800}, {8'h20, 16'h0008}, {8'h40, 16'h0008},
    {8'h80, 16'h0000}, {8'hFF, 16'h0828}, {8'h5A, 16'h0828},
    {8'hA5, 16'h0028}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tbl_wr(input logic [4:0] s, input logic [15:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_slot = s; tbl_wdata = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic sci_case(input logic [2:0] sel, input logic [15:0] pe,
                          input logic [23:0] ae, input string req);
    reg_wr(4'hC, {5'd0, sel});
    #1;
    check({req, " pic"}, 32'(pic_irq), 32'(pe));
    check({req, " apic"}, 32'(apic_irq), 32'(ae));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pirq_lvl = 8'hFF;
    @(negedge clk); #1;
    // R1: all routes disabled after reset
    check("R1 reset pic", 32'(pic_irq), 32'h0);
    // R6: upper APIC byte mirrors lines
    check("R6 reset apic", 32'(apic_irq), 32'hFF0000);
    // R9: default swizzle
    lk_slot = 5'd0; lk_pin = 2'd0; #1;
    check("R9 slot0 pinA", 32'(lk_pirq), 32'd4);
    lk_slot = 5'd3; lk_pin = 2'd2; #1;
    check("R9 slot3 pinC", 32'(lk_pirq), 32'd5);
    tbl_rd_slot = 5'd1; #1;
    check("R9 slot1 word", 32'(tbl_rd_data), 32'h4765);
    tbl_rd_slot = 5'd30; #1;
    check("R11 fixed readback", 32'(tbl_rd_data), 32'h0);
    lk_slot = 5'd30; lk_pin = 2'd1; #1;
    check("R11 fixed lookup", 32'(lk_pirq), 32'd5);

    // Route setting for the vector table
    pirq_lvl = 8'h00;
    reg_wr(4'hC, 8'h03);   // reserved SCI code
    reg_wr(4'h1, 8'h05);
    reg_wr(4'h2, 8'h87);   // disabled
    reg_wr(4'h3, 8'h14);   // target 20: R5
    reg_wr(4'h8, 8'h0B);
    reg_wr(4'h9, 8'h03);
    reg_wr(4'hA, 8'h03);
    reg_wr(4'hB, 8'h8E);   // disabled
    // R12: route takes effect at the storing edge
    pirq_lvl = 8'h01;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'h0; cfg_wdata = 8'h05;
    #1;
    check("R12 before edge", 32'(pic_irq), 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R12 after edge", 32'(pic_irq), 32'h0020);

    // R3 R4 R5 R6: table walk
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      pirq_lvl = VEC[i][23:16];
      #1;
      check("R3/R4/R5 pic vector", 32'(pic_irq), 32'(VEC[i][15:0]));
      check("R6 apic vector", 32'(apic_irq), {8'd0, VEC[i][23:16], 16'd0});
    end

    // R2: unused addresses are ignored
    reg_wr(4'h4, 8'h01);
    reg_wr(4'hD, 8'h00);
    reg_wr(4'h7, 8'h09);
    pirq_lvl = 8'hFF; #1;
    check("R2 unused addr", 32'(pic_irq), 32'h0828);
    // R2: second group, byte 3 is line 7
    reg_wr(4'hB, 8'h0F);
    pirq_lvl = 8'h80; #1;
    check("R2 group two", 32'(pic_irq), 32'h8000);

    // R7 R8: SCI path with lines quiet
    pirq_lvl = 8'h00;
    reg_wr(4'hC, 8'h00);
    @(negedge clk);
    sci_lvl = 1'b1; #1;
    check("R8 sci before edge", 32'(pic_irq), 32'h0);
    @(negedge clk); #1;
    check("R8 sci after edge pic", 32'(pic_irq), 32'h0200);
    check("R7 sci 9 apic", 32'(apic_irq), 32'h000200);
    sci_case(3'd1, 16'h0400, 24'h000400, "R7 sel1");
    sci_case(3'd2, 16'h0800, 24'h000800, "R7 sel2");
    sci_case(3'd4, 16'h0000, 24'h100000, "R7 sel4");
    sci_case(3'd5, 16'h0000, 24'h200000, "R7 sel5");
    sci_case(3'd3, 16'h0000, 24'h000000, "R7 sel3 reserved");
    sci_case(3'd7, 16'h0000, 24'h000000, "R7 sel7 reserved");
    reg_wr(4'hC, 8'h01);
    @(negedge clk);
    sci_lvl = 1'b1;       // same level again: held
    @(negedge clk); #1;
    check("R8 repeated level", 32'(pic_irq), 32'h0400);
    sci_lvl = 1'b0;
    @(negedge clk); #1;
    check("R8 sci drop", 32'(pic_irq), 32'h0);

    // R10: table write and readback
    tbl_wr(5'd2, 16'hF123);
    lk_slot = 5'd2; lk_pin = 2'd0; #1;
    check("R10 pinA", 32'(lk_pirq), 32'd3);
    lk_pin = 2'd3; #1;
    check("R10 pinD", 32'(lk_pirq), 32'd7);
    tbl_rd_slot = 5'd2; #1;
    check("R10 readback", 32'(tbl_rd_data), 32'h7123);
    // R11: fixed slot ignores writes
    tbl_wr(5'd30, 16'h0000);
    lk_slot = 5'd30; lk_pin = 2'd3; #1;
    check("R11 fixed after write", 32'(lk_pirq), 32'd7);
    tbl_rd_slot = 5'd30; #1;
    check("R11 readback zero", 32'(tbl_rd_data), 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule